// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block behaves as the slave side of a three-wire serial EEPROM so that a host-side controller can be exercised against it inside a larger design. The host raises a select line, clocks a start bit, a two-bit opcode and an address on the serial input, and either receives data on the serial output or supplies data to be stored. Storage is a small register array. Its contents survive until they are reprogrammed or the block is reset, and reset leaves every byte erased (all ones).

All three serial inputs are oversampled by the system clock through synchronizers, and the rising edge of the serial clock is detected in the system clock domain. An organization strap selects either 8-bit data with a 9-bit address or 16-bit data with an 8-bit address. Programming operations are gated by an enable latch that is cleared at reset. Each programming operation starts a self-timed busy period that lasts a parameterized number of system clocks. If the host drops select and raises it again during that period, the serial output reports the busy or ready state.

Top module: `sermem_dev`

## Requirements
- R1: After select rises, serial-input zeros sampled on serial-clock rising edges are skipped. The first 1 is the start bit. It is followed by a 2-bit opcode and then the address, most significant bit first.
- R2: Read uses opcode 10. On the rising edge that carries the last address bit, the output drives a single 0. Each later rising edge presents the next data bit, most significant first, and the output enable is high throughout.
- R3: While select stays high after a read word, the address advances by one and the next word follows immediately, with no 0 inserted between words.
- R4: With the organization strap at 1, the address is 8 bits and the data is 16 bits. With the strap at 0, the address is 9 bits and the data is 8 bits. Word w occupies byte 2w in bits 15:8 and byte 2w+1 in bits 7:0.
- R5: After reset, programming is locked. Write, erase, erase-all and write-all leave memory unchanged and start no busy period, while read still works.
- R6: Opcode 00 is refined by the two top address bits. The value 11 unlocks programming and 00 locks it again, and the state persists across instructions until changed.
- R7: Write uses opcode 01, with the data following the address. The data replaces the old contents without a prior erase.
- R8: Erase (opcode 11) sets the addressed location to all ones. Under opcode 00, sub-code 10 sets every location to all ones and sub-code 01 writes the supplied data to every location.
- R9: A programming operation makes the block busy for PROG_CYCLES system clocks after its last bit. If select is raised during that period, the output is enabled and reads 0 while busy, then 1 once the period ends.
- R10: If select is raised only after the busy period has ended, the output enable stays low.
- R11: The output enable is low whenever select is low, including the cycle right after select falls and the state after reset.
- R12: Storage holds STORE_BYTES bytes, and byte addresses are taken modulo STORE_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset: locks programming, erases storage |
| sel_i | input | 1 | Chip select, frames each instruction |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in, sampled on serial-clock rising edges |
| wide_i | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| sdo_o | output | 1 | Serial data out / ready-busy level |
| sdo_en_o | output | 1 | Output enable; low means high impedance |

## Verification
A word is written in 16-bit organization and read back as two bytes in 8-bit organization. This shows whether the byte order within a word and the differing address lengths are decoded correctly. Reads preceded by stray zeros and a three-word sequential read are used to detect a misplaced start bit or a dummy bit wrongly inserted between words. Writes issued while locked, after an unlock and after a re-lock show whether the enable latch gates programming without affecting read. Select is re-raised once during the busy period and once after it, which separates status reporting from idle high impedance. Erase, erase-all, write-all, overwrite and an aliased address complete the checks on the memory contents.

// File: rtl/sm_pkg.sv
package sm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_WAIT, ST_HDR, ST_DIN, ST_RD, ST_STAT, ST_DONE
   } sm_state_e;

   typedef enum logic [2:0] {
      MOP_NONE, MOP_WRITE1, MOP_ERASE1, MOP_WRALL, MOP_ERALL
   } mem_op_e;

   // opcode that follows the start bit
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_ERASE = 2'b11;
   // sub-codes in the top address bits when the opcode is 00
   localparam logic [1:0] SUB_ENABLE  = 2'b11;
   localparam logic [1:0] SUB_DISABLE = 2'b00;
   localparam logic [1:0] SUB_ERALL   = 2'b10;
   localparam logic [1:0] SUB_WRALL   = 2'b01;
endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("sm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sm_prog_timer.sv
module sm_prog_timer #(
   parameter int PROG_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 1) begin : g_bad_time
      $error("sm_prog_timer: PROG_CYCLES must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= CW'(PROG_CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/sm_array.sv
module sm_array
   import sm_pkg::*;
#(
   parameter int STORE_BYTES = 32,
   parameter int AW_MAX      = 9,
   parameter int DW_MAX      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  mem_op_e           mop_i,
   input  logic [AW_MAX-1:0] waddr_i,
   input  logic [DW_MAX-1:0] wdata_i,
   input  logic [AW_MAX-1:0] raddr_i,
   output logic [DW_MAX-1:0] rdata_o
);
   localparam int SB = $clog2(STORE_BYTES);
   localparam int BW = DW_MAX / 2;

   if (STORE_BYTES < 4 || (1 << SB) != STORE_BYTES || STORE_BYTES > (1 << AW_MAX))
   begin : g_bad_store
      $error("sm_array: STORE_BYTES must be a power of two in [4, 2**AW_MAX]");
   end

   logic [STORE_BYTES-1:0][BW-1:0] bytes_w;

   for (genvar i = 0; i < STORE_BYTES; i++) begin : g_byte
      localparam logic [SB-1:0] IDX = SB'(i);
      logic          hit;
      logic [BW-1:0] val;
      logic [BW-1:0] byte_q;

      always_comb begin
         hit = wide_i ? (IDX[SB-1:1] == waddr_i[SB-2:0]) : (IDX == waddr_i[SB-1:0]);
         val = (wide_i && !IDX[0]) ? wdata_i[DW_MAX-1:BW] : wdata_i[BW-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) byte_q <= '1;
         else begin
            case (mop_i)
               MOP_WRITE1: if (hit) byte_q <= val;
               MOP_ERASE1: if (hit) byte_q <= '1;
               MOP_WRALL:  byte_q <= val;
               MOP_ERALL:  byte_q <= '1;
               default: ;
            endcase
         end
      end

      assign bytes_w[i] = byte_q;
   end

   assign rdata_o = wide_i
      ? {bytes_w[{raddr_i[SB-2:0], 1'b0}], bytes_w[{raddr_i[SB-2:0], 1'b1}]}
      : {bytes_w[raddr_i[SB-1:0]], {BW{1'b0}}};

   logic unused_addr_hi;
   assign unused_addr_hi = ^{waddr_i[AW_MAX-1:SB-1], raddr_i[AW_MAX-1:SB-1]};
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl
   import sm_pkg::*;
#(
   parameter int AW_MAX = 9,
   parameter int DW_MAX = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sck_rise_i,
   input  logic              sdi_i,
   input  logic              wide_i,
   input  logic              busy_i,
   input  logic [DW_MAX-1:0] rdata_i,
   output logic [AW_MAX-1:0] raddr_o,
   output logic [AW_MAX-1:0] waddr_o,
   output logic [DW_MAX-1:0] wdata_o,
   output mem_op_e           mop_o,
   output logic              sdo_o,
   output logic              drive_o
);
   localparam int HW = AW_MAX + 2;
   localparam int CW = $clog2(HW + DW_MAX);

   sm_state_e         st_q;
   mem_op_e           mop_q;
   logic [HW-2:0]     hdr_q;
   logic [CW-1:0]     cnt_q, rcnt_q;
   logic [DW_MAX-1:0] din_q, rsh_q;
   logic [AW_MAX-1:0] ra_q, wa_q;
   logic              wen_q, all_q, sdo_q, drv_q;

   logic [HW-1:0]     hdr_nx;
   logic [DW_MAX-1:0] din_nx;
   logic [1:0]        op, sub;
   logic [AW_MAX-1:0] addr, ra_inc;
   logic [CW-1:0]     hdr_last, dat_last;

   always_comb begin
      hdr_nx   = {hdr_q, sdi_i};
      din_nx   = {din_q[DW_MAX-2:0], sdi_i};
      op       = wide_i ? hdr_nx[AW_MAX:AW_MAX-1] : hdr_nx[AW_MAX+1:AW_MAX];
      addr     = wide_i ? {1'b0, hdr_nx[AW_MAX-2:0]} : hdr_nx[AW_MAX-1:0];
      sub      = wide_i ? addr[AW_MAX-2:AW_MAX-3] : addr[AW_MAX-1:AW_MAX-2];
      hdr_last = wide_i ? CW'(HW - 2) : CW'(HW - 1);
      dat_last = wide_i ? CW'(DW_MAX - 1) : CW'(DW_MAX / 2 - 1);
      ra_inc   = wide_i ? {1'b0, ra_q[AW_MAX-2:0] + 1'b1} : ra_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  mop_q <= MOP_NONE;
         hdr_q <= '0;      cnt_q <= '0;  rcnt_q <= '0;
         din_q <= '0;      rsh_q <= '0;
         ra_q <= '0;       wa_q <= '0;
         wen_q <= 1'b0;    all_q <= 1'b0; sdo_q <= 1'b0; drv_q <= 1'b0;
      end else begin
         mop_q <= MOP_NONE;
         if (!sel_i) begin
            st_q  <= ST_IDLE;
            drv_q <= 1'b0;
         end else begin
            case (st_q)
               ST_IDLE: begin
                  if (busy_i) begin
                     st_q <= ST_STAT; drv_q <= 1'b1; sdo_q <= 1'b0;
                  end else st_q <= ST_WAIT;
               end
               ST_WAIT: if (sck_rise_i && sdi_i) begin
                  st_q <= ST_HDR; cnt_q <= '0;
               end
               ST_HDR: if (sck_rise_i) begin
                  hdr_q <= hdr_nx[HW-2:0];
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == hdr_last) begin
                     cnt_q <= '0;
                     st_q  <= ST_DONE;
                     wa_q  <= addr;
                     case (op)
                        OP_READ: begin
                           st_q <= ST_RD; ra_q <= addr; rcnt_q <= '0;
                           sdo_q <= 1'b0; drv_q <= 1'b1;
                        end
                        OP_WRITE: if (wen_q) begin st_q <= ST_DIN; all_q <= 1'b0; end
                        OP_ERASE: if (wen_q) mop_q <= MOP_ERASE1;
                        default: begin
                           case (sub)
                              SUB_ENABLE:  wen_q <= 1'b1;
                              SUB_DISABLE: wen_q <= 1'b0;
                              SUB_ERALL:   if (wen_q) mop_q <= MOP_ERALL;
                              default:     if (wen_q) begin st_q <= ST_DIN; all_q <= 1'b1; end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DIN: if (sck_rise_i) begin
                  din_q <= din_nx;
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == dat_last) begin
                     st_q  <= ST_DONE;
                     mop_q <= all_q ? MOP_WRALL : MOP_WRITE1;
                  end
               end
               ST_RD: if (sck_rise_i) begin
                  if (rcnt_q == '0) begin
                     sdo_q  <= rdata_i[DW_MAX-1];
                     rsh_q  <= {rdata_i[DW_MAX-2:0], 1'b0};
                     rcnt_q <= dat_last;
                     ra_q   <= ra_inc;
                  end else begin
                     sdo_q  <= rsh_q[DW_MAX-1];
                     rsh_q  <= {rsh_q[DW_MAX-2:0], 1'b0};
                     rcnt_q <= rcnt_q - 1'b1;
                  end
               end
               ST_STAT: sdo_q <= ~busy_i;
               default: ;
            endcase
         end
      end
   end

   assign raddr_o = ra_q;
   assign waddr_o = wa_q;
   assign wdata_o = din_q;
   assign mop_o   = mop_q;
   assign sdo_o   = sdo_q;
   assign drive_o = drv_q;

   AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD && $past(st_q) != ST_RD) |-> !sdo_q); // R2
   AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (mop_q != MOP_NONE) |-> wen_q); // R5
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mop_q != MOP_NONE) |-> !busy_i); // R9
   AST_IDLE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !drv_q); // R11
endmodule

// File: rtl/sermem_dev.sv
module sermem_dev
   import sm_pkg::*;
#(
   parameter int STORE_BYTES = 32,
   parameter int PROG_CYCLES = 100,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic wide_i,
   output logic sdo_o,
   output logic sdo_en_o
);
   logic [2:0]        syn;
   logic              sck_d, sck_rise, busy, drive;
   mem_op_e           mop;
   logic [ADDR_W-1:0] raddr, waddr;
   logic [DATA_W-1:0] rdata, wdata;

   sm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({sel_i, sclk_i, sdi_i}), .q_o(syn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= syn[1];
   end
   assign sck_rise = syn[1] & ~sck_d;

   sm_ctrl #(.AW_MAX(ADDR_W), .DW_MAX(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sel_i(syn[2]), .sck_rise_i(sck_rise), .sdi_i(syn[0]),
      .wide_i(wide_i), .busy_i(busy), .rdata_i(rdata),
      .raddr_o(raddr), .waddr_o(waddr), .wdata_o(wdata),
      .mop_o(mop), .sdo_o(sdo_o), .drive_o(drive)
   );

   sm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start_i(mop != MOP_NONE), .busy_o(busy)
   );

   sm_array #(.STORE_BYTES(STORE_BYTES), .AW_MAX(ADDR_W), .DW_MAX(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .mop_i(mop),
      .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata)
   );

   // raw select gates the enable so high impedance follows select at once
   assign sdo_en_o = sel_i & drive;
endmodule

// File: tb/tb_sermem_dev.sv
module tb_sermem_dev;
   localparam int PROG = 100;

   logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0, wide = 1'b1;
   logic sdo, sdo_en;
   int   checks = 0, errors = 0;

   always #5 clk = ~clk;

   sermem_dev #(.PROG_CYCLES(PROG)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
      .wide_i(wide), .sdo_o(sdo), .sdo_en_o(sdo_en)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int aw();
      return wide ? 8 : 9;
   endfunction
   function automatic int dw();
      return wide ? 16 : 8;
   endfunction

   task automatic tick(input logic b, output logic o, output logic e);
      sdi = b; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(4);
      o = sdo; e = sdo_en;
   endtask
   task automatic put(input logic b);
      logic o, e;
      tick(b, o, e);
   endtask
   task automatic cs_on();
      sel = 1'b1; wait_clk(4);
   endtask
   task automatic cs_off();
      sdi = 1'b0; sel = 1'b0; wait_clk(8);
   endtask

   task automatic header(input logic [1:0] op, input logic [8:0] a, output logic o, output logic e);
      tick(1'b1, o, e); tick(op[1], o, e); tick(op[0], o, e);
      for (int k = aw() - 1; k >= 0; k--) tick(a[k], o, e);
   endtask
   task automatic send_data(input logic [15:0] d);
      for (int k = dw() - 1; k >= 0; k--) put(d[k]);
   endtask
   function automatic logic [8:0] ext_addr(input logic [1:0] sub);
      return wide ? {1'b0, sub, 6'b0} : {sub, 7'b0};
   endfunction

   task automatic ext(input logic [1:0] sub);
      logic o, e;
      cs_on(); header(2'b00, ext_addr(sub), o, e); cs_off();
   endtask
   task automatic prog(input logic [1:0] op, input logic [8:0] a, input logic [15:0] d,
                       input logic with_data);
      logic o, e;
      cs_on(); header(op, a, o, e);
      if (with_data) send_data(d);
      cs_off(); wait_clk(PROG + 20);
   endtask
   task automatic read_word(input logic [8:0] a, input int pre, output logic [15:0] v,
                            output logic dummy, output logic en);
      logic o, e;
      cs_on();
      for (int k = 0; k < pre; k++) put(1'b0);
      header(2'b10, a, dummy, en);
      v = '0;
      for (int k = 0; k < dw(); k++) begin tick(1'b0, o, e); v = {v[14:0], o}; end
      cs_off();
   endtask

   task automatic t_reset();
      check("R11 enable low after reset", {15'b0, sdo_en}, 16'h0);
   endtask

   task automatic t_locked();
      logic [15:0] v; logic d, e;
      wide = 1'b1;
      prog(2'b01, 9'd3, 16'h1234, 1'b1);
      cs_on(); wait_clk(6);
      check("R5 no busy period while locked", {15'b0, sdo_en}, 16'h0);
      cs_off();
      read_word(9'd3, 0, v, d, e);
      check("R5 locked write ignored, read works", v, 16'hFFFF);
   endtask

   task automatic t_write_word();
      logic [15:0] v; logic d, e;
      ext(2'b11);
      prog(2'b01, 9'd3, 16'hA5C3, 1'b1);
      read_word(9'd3, 0, v, d, e);
      check("R7 word written after unlock", v, 16'hA5C3);
      check("R2 dummy bit is 0", {15'b0, d}, 16'h0);
      check("R2 output enabled in read", {15'b0, e}, 16'h1);
      read_word(9'd3, 3, v, d, e);
      check("R1 leading zeros skipped", v, 16'hA5C3);
   endtask

   task automatic t_byte_org();
      logic [15:0] v; logic d, e;
      wide = 1'b0;
      read_word(9'd6, 0, v, d, e);
      check("R4 byte 6 is word 3 high", v, 16'h00A5);
      read_word(9'd7, 0, v, d, e);
      check("R4 byte 7 is word 3 low", v, 16'h00C3);
      prog(2'b01, 9'd9, 16'h005A, 1'b1);
      read_word(9'd9, 0, v, d, e);
      check("R7 byte write", v, 16'h005A);
      read_word(9'd41, 0, v, d, e);
      check("R12 address aliases modulo storage", v, 16'h005A);
      prog(2'b01, 9'd9, 16'h0081, 1'b1);
      read_word(9'd9, 0, v, d, e);
      check("R7 overwrite without erase", v, 16'h0081);
      prog(2'b11, 9'd9, 16'h0, 1'b0);
      read_word(9'd9, 0, v, d, e);
      check("R8 erase sets ones", v, 16'h00FF);
   endtask

   task automatic t_seq();
      logic o, e; logic [23:0] s;
      wide = 1'b0;
      cs_on(); header(2'b10, 9'd5, o, e);
      s = '0;
      for (int k = 0; k < 24; k++) begin tick(1'b0, o, e); s = {s[22:0], o}; end
      cs_off();
      check("R3 sequential first two bytes", s[23:8], 16'hFFA5);
      check("R3 sequential third byte", {8'h00, s[7:0]}, 16'h00C3);
   endtask

   task automatic t_status();
      logic o, e; logic [15:0] v; logic d;
      wide = 1'b1;
      cs_on(); header(2'b01, 9'd4, o, e); send_data(16'h0FF0); cs_off();
      cs_on(); wait_clk(4);
      check("R9 status enabled while busy", {15'b0, sdo_en}, 16'h1);
      check("R9 busy reads 0", {15'b0, sdo}, 16'h0);
      wait_clk(PROG + 10);
      check("R9 ready reads 1", {14'b0, sdo_en, sdo}, 16'h3);
      cs_off();
      cs_on(); wait_clk(4);
      check("R10 no status after cycle ended", {15'b0, sdo_en}, 16'h0);
      cs_off();
      read_word(9'd4, 0, v, d, e);
      check("R7 data from status test", v, 16'h0FF0);
   endtask

   task automatic t_all();
      logic o, e; logic [15:0] v; logic d;
      wide = 1'b1;
      cs_on(); header(2'b00, ext_addr(2'b01), o, e); send_data(16'h3C96); cs_off();
      wait_clk(PROG + 20);
      read_word(9'd0, 0, v, d, e);
      check("R8 write-all word 0", v, 16'h3C96);
      read_word(9'd15, 0, v, d, e);
      check("R8 write-all word 15", v, 16'h3C96);
      prog(2'b00, ext_addr(2'b10), 16'h0, 1'b0);
      read_word(9'd7, 0, v, d, e);
      check("R8 erase-all", v, 16'hFFFF);
   endtask

   task automatic t_disable();
      logic [15:0] v; logic d, e;
      wide = 1'b1;
      ext(2'b00);
      prog(2'b01, 9'd1, 16'h0000, 1'b1);
      read_word(9'd1, 0, v, d, e);
      check("R6 relocked write ignored", v, 16'hFFFF);
   endtask

   task automatic t_hiz();
      logic o, e;
      wide = 1'b1;
      cs_on(); header(2'b10, 9'd1, o, e);
      check("R2 enable during read", {15'b0, e}, 16'h1);
      sel = 1'b0; @(negedge clk);
      check("R11 enable drops with select", {15'b0, sdo_en}, 16'h0);
      sdi = 1'b0; wait_clk(8);
   endtask

   initial begin
      wait_clk(5); rst_n = 1'b1; wait_clk(5);
      t_reset();
      t_locked();
      t_write_word();
      t_byte_org();
      t_seq();
      t_status();
      t_all();
      t_disable();
      t_hiz();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule